// File: doc/BRIEF.md
# Numeric Coprocessor Link Controller

This block sits on the processor side of the link to a numeric coprocessor. It reads two strap levels as reset ends. The busy pin decides whether an internal self-test is wanted. The error pin, read a few clocks later, tells whether the attached coprocessor is the 16-bit type or the 32-bit type. Both results are kept until the next reset.

After the straps are settled, the block gates the issue of coprocessor instructions on the busy line. Instructions that work on the numeric stack, and the wait instruction, stall while busy is asserted. The initialise and clear-exception instructions are exempt and issue at once.

The block also services operand-transfer requests from the coprocessor, one transfer at a time. For each transfer it tells the bus unit three things: the direction, which comes from the opcode the processor holds rather than from the coprocessor; the width, which follows the sensed type; and that the 16-bit bus-size input must be ignored. The request, busy and error pins are asynchronous. Each passes through a two-flop synchronizer before any logic uses it.

Top module: `copro_link_ctrl`

## Requirements
- R1: `selftest_req` takes the inverse of `busy_n` as seen on the first clock after `rst` falls (busy low means a self-test is wanted). It keeps that value until the next reset.
- R2: `strap_valid` rises after the fourth rising edge following the release of `rst`. On that same edge `type32` captures the inverse of `error_n`: low selects the 32-bit type (1) and high selects the 16-bit type (0). Later changes on `error_n` do not alter `type32`.
- R3: For instruction class 0 (stack operation) and class 1 (wait), `issue_ok` is high only when `instr_valid` is high and the synchronized `busy_n` is high.
- R4: For class 2 (initialise) and class 3 (clear exception), `issue_ok` follows `instr_valid` whatever the level of `busy_n`.
- R5: `issue_ok` stays low until `strap_valid` is high.
- R6: An asserted request produces a one-cycle `xfer_start` pulse and raises `xfer_busy`. No further start occurs until `xfer_done` ends the transfer. The request is re-checked on the cycle after that, so a held request starts the next transfer one idle cycle later.
- R7: While `xfer_busy` is high, `xfer_wide` equals `type32` (1 = 32-bit transfer, 0 = 16-bit transfer) and `bs16_ignore` is high. Both are low while idle.
- R8: `xfer_dir` captures `stored_dir` on the edge that starts a transfer and holds it until the transfer ends, even if `stored_dir` changes meanwhile.
- R9: While `rst` is high, every output is low.
- R10: A change on `busy_n` or `req` reaches the block's decisions after exactly two rising edges. For `req`, the transfer then starts on the third edge.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | A coprocessor instruction is waiting to issue |
| instr_class | input | 2 | 0 stack op, 1 wait, 2 initialise, 3 clear exception |
| stored_dir | input | 1 | Direction from the held opcode, 1 = toward memory |
| busy_n | input | 1 | Coprocessor busy, active low, asynchronous |
| error_n | input | 1 | Coprocessor error, active low, type strap at reset exit |
| req | input | 1 | Operand transfer request, active high, asynchronous |
| xfer_done | input | 1 | Bus unit finished the current transfer |
| issue_ok | output | 1 | Instruction may issue this cycle |
| xfer_start | output | 1 | One-cycle pulse starting a transfer |
| xfer_busy | output | 1 | A transfer is in progress |
| xfer_dir | output | 1 | Direction of the current transfer |
| xfer_wide | output | 1 | 1 = 32-bit transfer, 0 = 16-bit |
| bs16_ignore | output | 1 | Bus unit must disregard the bus-size input |
| type32 | output | 1 | Sensed coprocessor is the 32-bit type |
| selftest_req | output | 1 | Self-test requested at reset exit |
| strap_valid | output | 1 | Straps have been captured |

## Verification
The straps are swept over all four pairs of busy and error levels. Each pair shows whether self-test and type are latched from the right pin, at the right clock, and with the right polarity.

Issue gating is tried with every instruction class at both busy levels. This separates the exempt classes from the stalling ones. A single busy toggle, sampled one edge early, exposes a wrong synchronizer depth.

Transfers run for both types with alternating directions and with the request held across several transfers. Direction changes in mid-transfer show whether direction is latched or passed straight through. Dropping the request in mid-transfer shows whether it is re-checked or remembered.

// File: rtl/copro_pkg.sv
package copro_pkg;

  typedef enum logic [1:0] {
    CLS_STACK = 2'd0,
    CLS_WAIT  = 2'd1,
    CLS_INIT  = 2'd2,
    CLS_CLREX = 2'd3
  } instr_cls_e;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_ACT  = 1'b1
  } xfer_state_e;

  // Classes allowed to issue while the coprocessor is busy
  function automatic logic cls_exempt(instr_cls_e c);
    return (c == CLS_INIT) || (c == CLS_CLREX);
  endfunction

  // Issue permission from class, validity and synchronized busy
  function automatic logic issue_rule(logic valid, instr_cls_e c, logic busy_act);
    return valid && (cls_exempt(c) || !busy_act);
  endfunction

endpackage

// File: rtl/copro_sync.sv
module copro_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) stage[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk) stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/copro_strap.sv
module copro_strap #(
  parameter int TYPE_DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_act_s,
  input  logic err_act_s,
  output logic selftest_req,
  output logic type32,
  output logic strap_valid
);

  localparam int CW = $clog2(TYPE_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(TYPE_DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          st_done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      st_done_q    <= 1'b0;
      selftest_req <= 1'b0;
      type32       <= 1'b0;
      strap_valid  <= 1'b0;
    end else begin
      if (!st_done_q) begin
        selftest_req <= busy_act_s;
        st_done_q    <= 1'b1;
      end
      if (!strap_valid) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          type32      <= err_act_s;
          strap_valid <= 1'b1;
        end
      end
    end
  end

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
    strap_valid |=> strap_valid && $stable(type32)); // R2
  AST_SELFTEST_HELD: assert property (@(posedge clk) disable iff (rst)
    st_done_q |=> $stable(selftest_req)); // R1

endmodule

// File: rtl/copro_xfer.sv
module copro_xfer
  import copro_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic req_s,
  input  logic stored_dir,
  input  logic type32,
  input  logic xfer_done,
  output logic xfer_start,
  output logic xfer_busy,
  output logic xfer_dir,
  output logic xfer_wide,
  output logic bs16_ignore
);

  xfer_state_e st_q;
  logic        launch;

  assign launch = (st_q == XS_IDLE) && enable && req_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= XS_IDLE;
      xfer_start <= 1'b0;
      xfer_dir   <= 1'b0;
      xfer_wide  <= 1'b0;
    end else begin
      xfer_start <= launch;
      case (st_q)
        XS_IDLE: if (launch) begin
          st_q      <= XS_ACT;
          xfer_dir  <= stored_dir;
          xfer_wide <= type32;
        end
        XS_ACT: if (xfer_done) begin
          st_q      <= XS_IDLE;
          xfer_wide <= 1'b0;
        end
        default: st_q <= XS_IDLE;
      endcase
    end
  end

  assign xfer_busy   = (st_q == XS_ACT);
  assign bs16_ignore = xfer_busy;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !xfer_start); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    xfer_busy && !xfer_done |=> xfer_busy && !xfer_start); // R6
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
    xfer_busy && !xfer_start |-> $stable(xfer_dir)); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> xfer_busy); // R6

endmodule

// File: rtl/copro_link_ctrl.sv
module copro_link_ctrl
  import copro_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TYPE_DLY    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       instr_valid,
  input  logic [1:0] instr_class,
  input  logic       stored_dir,
  input  logic       busy_n,
  input  logic       error_n,
  input  logic       req,
  input  logic       xfer_done,
  output logic       issue_ok,
  output logic       xfer_start,
  output logic       xfer_busy,
  output logic       xfer_dir,
  output logic       xfer_wide,
  output logic       bs16_ignore,
  output logic       type32,
  output logic       selftest_req,
  output logic       strap_valid
);

  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_pins, sync_pins;
  logic             busy_act_s, err_act_s, req_s;
  instr_cls_e       cls;

  assign raw_pins = {req, error_n, busy_n};

  copro_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw_pins),
    .q   (sync_pins)
  );

  assign busy_act_s = ~sync_pins[0];
  assign err_act_s  = ~sync_pins[1];
  assign req_s      =  sync_pins[2];

  copro_strap #(.TYPE_DLY(TYPE_DLY)) u_strap (
    .clk          (clk),
    .rst          (rst),
    .busy_act_s   (busy_act_s),
    .err_act_s    (err_act_s),
    .selftest_req (selftest_req),
    .type32       (type32),
    .strap_valid  (strap_valid)
  );

  assign cls      = instr_cls_e'(instr_class);
  assign issue_ok = strap_valid && !rst && issue_rule(instr_valid, cls, busy_act_s);

  copro_xfer u_xfer (
    .clk         (clk),
    .rst         (rst),
    .enable      (strap_valid),
    .req_s       (req_s),
    .stored_dir  (stored_dir),
    .type32      (type32),
    .xfer_done   (xfer_done),
    .xfer_start  (xfer_start),
    .xfer_busy   (xfer_busy),
    .xfer_dir    (xfer_dir),
    .xfer_wide   (xfer_wide),
    .bs16_ignore (bs16_ignore)
  );

  AST_ISSUE_NEEDS_STRAP: assert property (@(posedge clk) disable iff (rst)
    issue_ok |-> strap_valid); // R5
  AST_STACK_GATE: assert property (@(posedge clk) disable iff (rst)
    issue_ok && !cls_exempt(cls) |-> !busy_act_s); // R3
  AST_WIDE_MATCH: assert property (@(posedge clk) disable iff (rst)
    xfer_busy |-> xfer_wide == type32); // R7
  AST_START_NEEDS_STRAP: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> strap_valid); // R6

endmodule

// File: tb/copro_link_ctrl_tb.sv
`timescale 1ns/1ps
module copro_link_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       instr_valid = 1'b0;
  logic [1:0] instr_class = 2'd0;
  logic       stored_dir = 1'b0;
  logic       busy_n = 1'b1;
  logic       error_n = 1'b1;
  logic       req = 1'b0;
  logic       xfer_done = 1'b0;
  logic       issue_ok, xfer_start, xfer_busy, xfer_dir, xfer_wide;
  logic       bs16_ignore, type32, selftest_req, strap_valid;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  copro_link_ctrl u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_class(instr_class),
    .stored_dir(stored_dir), .busy_n(busy_n), .error_n(error_n), .req(req),
    .xfer_done(xfer_done), .issue_ok(issue_ok), .xfer_start(xfer_start),
    .xfer_busy(xfer_busy), .xfer_dir(xfer_dir), .xfer_wide(xfer_wide),
    .bs16_ignore(bs16_ignore), .type32(type32), .selftest_req(selftest_req),
    .strap_valid(strap_valid)
  );

  task automatic check(input string req_tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_issue(logic v, logic [1:0] c, logic bn);
    return v && (c[1] || bn);
  endfunction

  // Reset, strap capture, and pre-strap issue blocking
  task automatic do_reset(input logic b, input logic e);
    rst = 1'b1; busy_n = b; error_n = e; req = 1'b0; xfer_done = 1'b0;
    instr_valid = 1'b1; instr_class = 2'd2;
    step(3);
    check("R9 outputs in reset",
          {issue_ok, xfer_start, xfer_busy, xfer_dir, xfer_wide, bs16_ignore, type32, selftest_req}, 8'h00);
    check("R9 strap_valid in reset", {7'd0, strap_valid}, 8'h00);
    rst = 1'b0;
    step(1);
    check("R1 selftest latched", {7'd0, selftest_req}, {7'd0, ~b});
    step(2);
    check("R2 strap not yet valid", {7'd0, strap_valid}, 8'h00);
    check("R5 no issue before strap", {7'd0, issue_ok}, 8'h00);
    step(1);
    check("R2 strap valid at 4th edge", {7'd0, strap_valid}, 8'h01);
    check("R2 type polarity", {7'd0, type32}, {7'd0, ~e});
    check("R4 exempt issues after strap", {7'd0, issue_ok}, 8'h01);
    error_n = ~e; busy_n = ~b;
    step(4);
    check("R2 type held", {7'd0, type32}, {7'd0, ~e});
    check("R1 selftest held", {7'd0, selftest_req}, {7'd0, ~b});
  endtask

  task automatic run_xfers(input int n, input logic wide);
    stored_dir = wide;
    req = 1'b1;
    step(2);
    check("R10 req not seen early", {7'd0, xfer_start}, 8'h00);
    step(1);
    for (int i = 0; i < n; i++) begin
      logic d = (i % 2 == 1) ^ wide;
      check("R6 start pulse", {7'd0, xfer_start}, 8'h01);
      check("R7 width", {6'd0, xfer_wide, bs16_ignore}, {6'd0, wide, 1'b1});
      check("R8 dir captured", {7'd0, xfer_dir}, {7'd0, d});
      stored_dir = ~d;
      if (i == n - 1) req = 1'b0;
      step(3);
      check("R8 dir held", {7'd0, xfer_dir}, {7'd0, d});
      check("R6 no restart", {6'd0, xfer_start, xfer_busy}, 8'h01);
      xfer_done = 1'b1;
      stored_dir = ~d;
      step(1);
      xfer_done = 1'b0;
      check("R6 idle after done", {6'd0, xfer_start, xfer_busy}, 8'h00);
      check("R7 idle width", {6'd0, xfer_wide, bs16_ignore}, 8'h00);
      step(1);
      if (i == n - 1) begin
        for (int k = 0; k < 4; k++) begin
          check("R6 request re-checked", {6'd0, xfer_start, xfer_busy}, 8'h00);
          step(1);
        end
      end
    end
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int e = 0; e < 2; e++) begin
        do_reset(b[0], e[0]);
        // issue sweep
        for (int c = 0; c < 4; c++) begin
          for (int bn = 0; bn < 2; bn++) begin
            for (int v = 0; v < 2; v++) begin
              instr_class = c[1:0]; busy_n = bn[0]; instr_valid = v[0];
              step(2);
              check(c < 2 ? "R3 gated issue" : "R4 exempt issue",
                    {7'd0, issue_ok}, {7'd0, exp_issue(v[0], c[1:0], bn[0])});
            end
          end
        end
        // sync latency on busy for a stack op
        instr_class = 2'd0; instr_valid = 1'b1; busy_n = 1'b1;
        step(3);
        busy_n = 1'b0;
        step(1);
        check("R10 busy not seen after one edge", {7'd0, issue_ok}, 8'h01);
        step(1);
        check("R10 busy seen after two edges", {7'd0, issue_ok}, 8'h00);
        instr_class = 2'd1;
        check("R3 wait stalls", {7'd0, issue_ok}, 8'h00);
        run_xfers(3, ~e[0]);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule